// File: doc/BRIEF.md
# Host Command Loader for a Matrix Engine

This block connects a slow host processor to a matrix multiply engine through one shared message word and a pair of flow-control flags. The host places a command on the message lines, then raises valid; the loader answers by dropping ready while it works and raises ready again only once the host has withdrawn valid. Each message carries an opcode, an index field and a data field. Both the message and valid cross into the loader's clock through two-flop synchronisers.

The host configures the matrix size, selects the first operand matrix and streams its elements, selects the second and streams those, and then issues start. The loader forwards every element to the engine's write port with an index it counts up itself, pulses the engine's start input, and tracks the run until the engine reports completion. The host polls a done flag, or a status word, and then fetches result elements one at a time by index; each value comes back on a result register. Commands that arrive while the engine runs, other than a status request, are turned away and raise a sticky error flag.

Top module: `mld_host_loader`

## Requirements
- R1: After reset, host_ready is 1, host_done and host_err are 0, host_rdata is 0 and eng_size equals MAX_N.
- R2: The message is taken when synchronised valid is seen with ready high; ready then goes low and stays low while valid remains high, and returns to 1 only after valid has dropped.
- R3: Message layout is opcode in bits [2:0], index in the next IDX_W bits, data in the top DATA_W bits. Opcode 0 sets the size to the data field when it lies in 1..MAX_N; any other value is refused with host_err set and eng_size unchanged.
- R4: Opcode 1 selects the first matrix (eng_wr_sel 0) and opcode 2 the second (eng_wr_sel 1); each selection restarts the element counter at 0. Opcode 3 writes the data field to the engine at the counter value and advances it; the message index field is ignored. At most one of eng_wr_en, eng_start, eng_rd_en is high in any cycle.
- R5: A write with no matrix selected since reset, or once n*n elements have been written to the selected matrix, produces no engine write and sets host_err.
- R6: Opcode 4 pulses eng_start for one cycle and clears host_done; the loader is busy until eng_done, which sets host_done.
- R7: Opcode 5 pulses eng_rd_en with eng_rd_idx equal to the index field; the engine's data one cycle later is stored in host_rdata and is valid once ready has returned.
- R8: Opcode 6 is accepted at all times and loads host_rdata with bit 0 busy, bit 1 done, bit 2 error, other bits 0.
- R9: While busy, any opcode other than 6 produces no engine strobe and sets host_err; host_err stays set until reset.
- R10: Opcode 7 is refused and sets host_err.
- R11: A read whose index is not below n*n produces no engine read and sets host_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loader and engine clock |
| rst_n | input | 1 | Active-low reset |
| host_valid | input | 1 | Host flag: message lines hold a command |
| host_msg | input | MSG_W | Shared command word from the host |
| host_ready | output | 1 | Loader can take a new command |
| host_rdata | output | RES_W | Result element or status word |
| host_done | output | 1 | Last started computation has finished |
| host_err | output | 1 | Sticky refused-command flag |
| eng_size | output | SZ_W | Matrix dimension n for the engine |
| eng_wr_en | output | 1 | Element write strobe |
| eng_wr_sel | output | 1 | 0 first matrix, 1 second matrix |
| eng_wr_idx | output | IDX_W | Row-major element index for the write |
| eng_wr_data | output | DATA_W | Element value |
| eng_start | output | 1 | One-cycle start pulse |
| eng_done | input | 1 | Engine completion pulse |
| eng_rd_en | output | 1 | Result read strobe |
| eng_rd_idx | output | IDX_W | Result element index |
| eng_rd_data | input | RES_W | Result value, one cycle after the strobe |

## Verification
The bench builds the loader with MAX_N of 4, 16-bit elements and 40-bit results, so a full operand has only 16 elements and the n*n write limit, the out-of-range read index and the size bounds of 0 and MAX_N are all reached in a few dozen commands. A behavioural engine in the bench stores what arrives on the write port and multiplies with the size it sees on eng_size, so a wrong element order or matrix selection shows up in the result values. Two sizes, 3 and 2, are run end to end, and every refusal case starts from a fresh reset so the sticky flag of one case cannot mask the next.

// File: rtl/mld_pkg.sv
package mld_pkg;

  typedef enum logic [2:0] {
    OP_SIZE   = 3'd0,
    OP_SELA   = 3'd1,
    OP_SELB   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_START  = 3'd4,
    OP_READ   = 3'd5,
    OP_STATUS = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  localparam int unsigned OP_W = 3;

  // number of elements in an n by n matrix
  function automatic int unsigned elem_count(input int unsigned n);
    return n * n;
  endfunction

  // status word bit order: busy, done, error
  function automatic logic [2:0] status_bits(input logic busy, input logic done,
                                             input logic err);
    return {err, done, busy};
  endfunction

endpackage

// File: rtl/mld_sync.sv
module mld_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[b] <= 1'b0;
        stage2[b] <= 1'b0;
      end else begin
        stage1[b] <= d[b];
        stage2[b] <= stage1[b];
      end
    end
  end

  assign q = stage2;
endmodule

// File: rtl/mld_handshake.sv
module mld_handshake #(
  parameter int unsigned MSG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_s,
  input  logic [MSG_W-1:0] msg_s,
  input  logic             exec_done,
  output logic             ready,
  output logic             cap,
  output logic             go,
  output logic [MSG_W-1:0] msg_q
);
  typedef enum logic [1:0] {HS_IDLE, HS_WORK, HS_DROP} hs_e;
  hs_e st;

  assign ready = (st == HS_IDLE);
  assign cap   = ready & valid_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= HS_IDLE;
      go    <= 1'b0;
      msg_q <= '0;
    end else begin
      go <= cap;
      unique case (st)
        HS_IDLE: if (cap) begin
          msg_q <= msg_s;
          st    <= HS_WORK;
        end
        HS_WORK: if (exec_done) st <= HS_DROP;
        HS_DROP: if (!valid_s) st <= HS_IDLE;
        default: st <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mld_exec.sv
module mld_exec
  import mld_pkg::*;
#(
  parameter int unsigned MAX_N  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RES_W  = 40,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned SZ_W   = 3,
  parameter int unsigned MSG_W  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [MSG_W-1:0]  msg_q,
  input  logic              eng_done,
  input  logic [RES_W-1:0]  eng_rd_data,
  output logic              exec_done,
  output logic [SZ_W-1:0]   eng_size,
  output logic              eng_wr_en,
  output logic              eng_wr_sel,
  output logic [IDX_W-1:0]  eng_wr_idx,
  output logic [DATA_W-1:0] eng_wr_data,
  output logic              eng_start,
  output logic              eng_rd_en,
  output logic [IDX_W-1:0]  eng_rd_idx,
  output logic [RES_W-1:0]  host_rdata,
  output logic              host_done,
  output logic              host_err,
  output logic              busy,
  output logic              reject
);
  localparam int unsigned CNT_W = $clog2(MAX_N * MAX_N + 1);

  op_e               op;
  logic [IDX_W-1:0]  idx_f;
  logic [DATA_W-1:0] data_f;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  ptr_q;
  logic [SZ_W-1:0]   size_q;
  logic              sel_valid_q, sel_b_q;
  logic              busy_q, done_q, err_q, rd_wait_q;
  logic [RES_W-1:0]  rdata_q;
  logic              ok, act, size_ok;

  assign op     = op_e'(msg_q[OP_W-1:0]);
  assign idx_f  = msg_q[OP_W +: IDX_W];
  assign data_f = msg_q[OP_W+IDX_W +: DATA_W];
  assign limit  = CNT_W'(elem_count(32'(size_q)));
  assign size_ok = (data_f != '0) && (data_f <= DATA_W'(MAX_N));

  always_comb begin
    unique case (op)
      OP_SIZE:   ok = size_ok;
      OP_SELA:   ok = 1'b1;
      OP_SELB:   ok = 1'b1;
      OP_WRITE:  ok = sel_valid_q && (ptr_q < limit);
      OP_START:  ok = 1'b1;
      OP_READ:   ok = CNT_W'(idx_f) < limit;
      OP_STATUS: ok = 1'b1;
      default:   ok = 1'b0;
    endcase
    if (busy_q && op != OP_STATUS) ok = 1'b0;
  end

  assign act    = go & ok;
  assign reject = go & ~ok;

  assign eng_wr_en   = act && op == OP_WRITE;
  assign eng_wr_sel  = sel_b_q;
  assign eng_wr_idx  = ptr_q[IDX_W-1:0];
  assign eng_wr_data = data_f;
  assign eng_start   = act && op == OP_START;
  assign eng_rd_en   = act && op == OP_READ;
  assign eng_rd_idx  = idx_f;
  assign exec_done   = (go & ~eng_rd_en) | rd_wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q      <= SZ_W'(MAX_N);
      ptr_q       <= '0;
      sel_valid_q <= 1'b0;
      sel_b_q     <= 1'b0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      rd_wait_q   <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rd_wait_q <= eng_rd_en;
      if (rd_wait_q) rdata_q <= eng_rd_data;
      if (reject) err_q <= 1'b1;
      if (busy_q && eng_done) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      if (act) begin
        unique case (op)
          OP_SIZE:   size_q <= data_f[SZ_W-1:0];
          OP_SELA:   begin sel_valid_q <= 1'b1; sel_b_q <= 1'b0; ptr_q <= '0; end
          OP_SELB:   begin sel_valid_q <= 1'b1; sel_b_q <= 1'b1; ptr_q <= '0; end
          OP_WRITE:  ptr_q <= ptr_q + 1'b1;
          OP_START:  begin busy_q <= 1'b1; done_q <= 1'b0; end
          OP_STATUS: rdata_q <= RES_W'(status_bits(busy_q, done_q, err_q));
          default:   ;
        endcase
      end
    end
  end

  assign eng_size   = size_q;
  assign host_rdata = rdata_q;
  assign host_done  = done_q;
  assign host_err   = err_q;
  assign busy       = busy_q;
endmodule

// File: rtl/mld_host_loader.sv
module mld_host_loader
  import mld_pkg::*;
#(
  parameter int unsigned MAX_N  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RES_W  = 40,
  localparam int unsigned IDX_W = $clog2(MAX_N * MAX_N),
  localparam int unsigned SZ_W  = $clog2(MAX_N + 1),
  localparam int unsigned MSG_W = OP_W + IDX_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic [MSG_W-1:0]  host_msg,
  output logic              host_ready,
  output logic [RES_W-1:0]  host_rdata,
  output logic              host_done,
  output logic              host_err,
  output logic [SZ_W-1:0]   eng_size,
  output logic              eng_wr_en,
  output logic              eng_wr_sel,
  output logic [IDX_W-1:0]  eng_wr_idx,
  output logic [DATA_W-1:0] eng_wr_data,
  output logic              eng_start,
  input  logic              eng_done,
  output logic              eng_rd_en,
  output logic [IDX_W-1:0]  eng_rd_idx,
  input  logic [RES_W-1:0]  eng_rd_data
);
  logic             valid_s;
  logic [MSG_W-1:0] msg_s;
  logic [MSG_W-1:0] msg_q;
  logic             cap, go, exec_done, busy, reject;

  mld_sync #(.W(MSG_W + 1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_valid, host_msg}),
    .q({valid_s, msg_s})
  );

  mld_handshake #(.MSG_W(MSG_W)) u_hs (
    .clk(clk), .rst_n(rst_n),
    .valid_s(valid_s), .msg_s(msg_s), .exec_done(exec_done),
    .ready(host_ready), .cap(cap), .go(go), .msg_q(msg_q)
  );

  mld_exec #(
    .MAX_N(MAX_N), .DATA_W(DATA_W), .RES_W(RES_W),
    .IDX_W(IDX_W), .SZ_W(SZ_W), .MSG_W(MSG_W)
  ) u_exec (
    .clk(clk), .rst_n(rst_n), .go(go), .msg_q(msg_q),
    .eng_done(eng_done), .eng_rd_data(eng_rd_data),
    .exec_done(exec_done), .eng_size(eng_size),
    .eng_wr_en(eng_wr_en), .eng_wr_sel(eng_wr_sel),
    .eng_wr_idx(eng_wr_idx), .eng_wr_data(eng_wr_data),
    .eng_start(eng_start), .eng_rd_en(eng_rd_en), .eng_rd_idx(eng_rd_idx),
    .host_rdata(host_rdata), .host_done(host_done), .host_err(host_err),
    .busy(busy), .reject(reject)
  );
endmodule

// File: rtl/mld_host_loader_chk.sv
module mld_host_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic host_ready,
  input logic valid_s,
  input logic cap,
  input logic eng_wr_en,
  input logic eng_start,
  input logic eng_rd_en,
  input logic host_err,
  input logic host_done,
  input logic busy,
  input logic reject
);
  // R2
  cap_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !host_ready);

  // R2
  rearm_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ready) |-> !valid_s);

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_wr_en, eng_start, eng_rd_en}));

  // R6
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> (!host_done && busy));

  // R9
  busy_blocks_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(eng_wr_en || eng_start || eng_rd_en));

  // R9
  reject_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> host_err);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |=> host_err);
endmodule

bind mld_host_loader mld_host_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .valid_s(valid_s),
  .cap(cap), .eng_wr_en(eng_wr_en), .eng_start(eng_start),
  .eng_rd_en(eng_rd_en), .host_err(host_err), .host_done(host_done),
  .busy(busy), .reject(reject)
);

// File: tb/tb_mld_host_loader.sv
module tb_mld_host_loader;
  localparam int MAX_N = 4;
  localparam int DW    = 16;
  localparam int RW    = 40;
  localparam int IW    = 4;
  localparam int SW    = 3;
  localparam int MW    = 3 + IW + DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_valid = 1'b0;
  logic [MW-1:0] host_msg = '0;
  logic          host_ready, host_done, host_err;
  logic [RW-1:0] host_rdata;
  logic [SW-1:0] eng_size;
  logic          eng_wr_en, eng_wr_sel, eng_start, eng_rd_en;
  logic [IW-1:0] eng_wr_idx, eng_rd_idx;
  logic [DW-1:0] eng_wr_data;
  logic          eng_done = 1'b0;
  logic [RW-1:0] eng_rd_data = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mld_host_loader dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_msg(host_msg),
    .host_ready(host_ready), .host_rdata(host_rdata), .host_done(host_done),
    .host_err(host_err), .eng_size(eng_size), .eng_wr_en(eng_wr_en),
    .eng_wr_sel(eng_wr_sel), .eng_wr_idx(eng_wr_idx), .eng_wr_data(eng_wr_data),
    .eng_start(eng_start), .eng_done(eng_done), .eng_rd_en(eng_rd_en),
    .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data)
  );

  // behavioural engine
  logic [DW-1:0] ma [16];
  logic [DW-1:0] mb [16];
  logic [RW-1:0] mc [16];
  int wr_cnt = 0, rd_cnt = 0, eng_cnt = 0;

  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_wr_en) begin
      if (eng_wr_sel) mb[eng_wr_idx] = eng_wr_data;
      else            ma[eng_wr_idx] = eng_wr_data;
      wr_cnt++;
    end
    if (eng_rd_en) begin
      eng_rd_data <= mc[eng_rd_idx];
      rd_cnt++;
    end
    if (eng_start) begin
      for (int i = 0; i < int'(eng_size); i++)
        for (int j = 0; j < int'(eng_size); j++) begin
          logic [RW-1:0] acc;
          acc = '0;
          for (int k = 0; k < int'(eng_size); k++)
            acc += RW'(ma[i*int'(eng_size)+k]) * RW'(mb[k*int'(eng_size)+j]);
          mc[i*int'(eng_size)+j] = acc;
        end
      eng_cnt = 30;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) eng_done <= 1'b1;
    end
  end

  // host-side copies for expected values
  logic [DW-1:0] ha [16];
  logic [DW-1:0] hb [16];

  function automatic logic [RW-1:0] expect_elem(int n, int r, int c);
    logic [RW-1:0] s = '0;
    for (int k = 0; k < n; k++) s += RW'(ha[r*n+k]) * RW'(hb[k*n+c]);
    return s;
  endfunction

  task automatic check(string req, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [2:0] op, logic [IW-1:0] idx, logic [DW-1:0] data);
    host_msg = {data, idx, op};
    @(negedge clk);
    host_valid = 1'b1;
    while (host_ready) @(negedge clk);
    host_valid = 1'b0;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(int n, int seed);
    send(3'd0, '0, DW'(n));
    send(3'd1, '0, '0);
    for (int k = 0; k < n*n; k++) begin
      ha[k] = DW'(seed * 7 + k * 13 + 1);
      send(3'd3, IW'(k ^ 5), ha[k]);          // index field is junk (R4)
    end
    send(3'd2, '0, '0);
    for (int k = 0; k < n*n; k++) begin
      hb[k] = DW'(seed * 3 + k * 29 + 2);
      send(3'd3, IW'(15 - k), hb[k]);
    end
  endtask

  task automatic wait_done();
    for (int t = 0; t < 40; t++) begin
      send(3'd6, '0, '0);
      if (host_rdata[1]) break;
    end
  endtask

  // scoreboard
  logic [RW-1:0] expq[$];
  event rd_ev;

  initial begin
    forever begin
      @(rd_ev);
      if (expq.size() > 0) check("R7 result", host_rdata, expq.pop_front());
    end
  end

  task automatic read_res(int idx, logic [RW-1:0] exp);
    send(3'd5, IW'(idx), '0);
    expq.push_back(exp);
    -> rd_ev;
    @(negedge clk);
  endtask

  task automatic run_mult(int n, int seed);
    load(n, seed);
    check("R4 write count", RW'(wr_cnt), RW'(2*n*n));
    for (int k = 0; k < n*n; k++) begin
      check("R4 first matrix order", RW'(ma[k]), RW'(ha[k]));
      check("R4 second matrix order", RW'(mb[k]), RW'(hb[k]));
    end
    send(3'd4, '0, '0);
    check("R6 done cleared by start", RW'(host_done), 0);
    send(3'd6, '0, '0);
    check("R8 status while busy", host_rdata, RW'(3'b001));
    wait_done();
    check("R6 done set", RW'(host_done), 1);
    check("R8 status after done", host_rdata, RW'(3'b010));
    for (int r = 0; r < n; r++)
      for (int c = 0; c < n; c++) read_res(r*n+c, expect_elem(n, r, c));
    check("R7 read strobes", RW'(rd_cnt), RW'(n*n));
    check("R9 no error on clean flow", RW'(host_err), 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    do_reset();
    check("R1 ready", RW'(host_ready), 1);
    check("R1 done", RW'(host_done), 0);
    check("R1 err", RW'(host_err), 0);
    check("R1 rdata", host_rdata, 0);
    check("R1 size", RW'(eng_size), RW'(MAX_N));

    // R2: ready stays low while valid held, returns after drop
    host_msg = {DW'(0), IW'(0), 3'd6};
    @(negedge clk);
    host_valid = 1'b1;
    while (host_ready) @(negedge clk);
    repeat (8) @(negedge clk);
    check("R2 ready low while valid held", RW'(host_ready), 0);
    host_valid = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 ready back after valid drop", RW'(host_ready), 1);

    wr_cnt = 0; rd_cnt = 0;
    run_mult(3, 1);
    check("R3 size taken", RW'(eng_size), 3);
    wr_cnt = 0; rd_cnt = 0;
    run_mult(2, 5);

    // R3 size out of range
    do_reset();
    send(3'd0, '0, 16'd0);
    check("R3 size zero err", RW'(host_err), 1);
    check("R3 size unchanged", RW'(eng_size), RW'(MAX_N));
    do_reset();
    send(3'd0, '0, 16'd5);
    check("R3 size above max err", RW'(host_err), 1);
    check("R3 size unchanged above max", RW'(eng_size), RW'(MAX_N));

    // R5 write without selection
    do_reset();
    wr_cnt = 0;
    send(3'd3, '0, 16'h55);
    check("R5 unselected write err", RW'(host_err), 1);
    check("R5 unselected write dropped", RW'(wr_cnt), 0);

    // R5 write past n*n
    do_reset();
    wr_cnt = 0;
    send(3'd0, '0, 16'd2);
    send(3'd1, '0, '0);
    for (int k = 0; k < 4; k++) send(3'd3, '0, DW'(k + 9));
    check("R5 writes within limit no err", RW'(host_err), 0);
    send(3'd3, '0, 16'h77);
    check("R5 overflow write err", RW'(host_err), 1);
    check("R5 overflow write dropped", RW'(wr_cnt), 4);

    // R10 reserved opcode
    do_reset();
    send(3'd7, '0, '0);
    check("R10 reserved opcode err", RW'(host_err), 1);

    // R11 read index out of range
    do_reset();
    rd_cnt = 0;
    send(3'd0, '0, 16'd2);
    send(3'd5, IW'(4), '0);
    check("R11 read out of range err", RW'(host_err), 1);
    check("R11 read dropped", RW'(rd_cnt), 0);

    // R9 command while busy
    do_reset();
    wr_cnt = 0;
    send(3'd1, '0, '0);
    send(3'd4, '0, '0);
    send(3'd3, '0, 16'h33);
    check("R9 busy write err", RW'(host_err), 1);
    check("R9 busy write dropped", RW'(wr_cnt), 0);
    send(3'd6, '0, '0);
    check("R8 R9 status accepted while busy", host_rdata, RW'(3'b101));
    wait_done();
    check("R9 err sticky", RW'(host_err), 1);

    finish_run();
  end
endmodule